// File: doc/BRIEF.md
# Grouped Priority Interrupt Arbiter

This block collects up to 24 interrupt request lines, latches each one as pending, and picks one pending request to present to a processor core. A request is only considered when the global enable and that source's own enable are both set. The 24 sources form six groups of four. Each group is given one of four priority levels, and the highest level wins. When levels are equal, the lower source number wins.

Software programs the enables and the group levels through a small register port. Writes are synchronous and reads are combinational. The core sees a registered valid flag, a 5-bit source index and that source's level. A one-cycle acknowledge pulse clears the pending bit of the source currently shown, and arbitration then moves on to the next candidate.

Top module: `irq_group_arbiter`

## Requirements
- R1: After reset, req_valid_o, req_id_o and req_level_o are 0. All registers read 0, so every group is at level 0 and every enable is off.
- R2: A high irq_i[n], sampled on a clock edge, sets pending bit n. A pending bit stays set until it is acknowledged. The outputs show the arbitration result over the pending vector as it stood at the previous edge, so an irq_i pulse reaches the outputs at the second edge after it is sampled.
- R3: Group g (0 to 5) holds sources g, g+6, g+12 and g+18. Its level is {bit g of register 5, bit g of register 4}, so register 5 supplies the MSB. Level 3 is the highest and level 0 the lowest.
- R4: Among the eligible sources, the one in the highest-level group wins. req_level_o reports that level.
- R5: When eligible sources share the highest level, the lowest source number wins. This holds within one group and across different groups.
- R6: Register 0 bit 6 is the global enable. While it is 0, req_valid_o stays 0 and pending bits are kept.
- R7: Enable register r (addresses 0 to 3) bit b enables source 6r+b. A disabled pending source is never selected. It becomes eligible again, with no new request, once its enable is set.
- R8: When ack_i is high and req_valid_o is high, the pending bit of req_id_o clears at that edge. If no other source is eligible, req_valid_o is 0 after the next edge.
- R9: If ack_i clears a source in the same cycle that irq_i for that source is high, the source stays pending.
- R10: A write to address 0 stores wdata[6:0]. A write to addresses 1 to 5 stores wdata[5:0] and reads bit 6 as 0. Addresses 6 and 7 read 0 and ignore writes.
- R11: A change to a level or an enable made by a write is reflected in the outputs after the next edge following the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 24 | Interrupt request lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 7 | Register write data |
| reg_rdata_o | output | 7 | Register read data (combinational) |
| ack_i | input | 1 | Clears the pending bit of the shown source |
| req_valid_o | output | 1 | A request is being presented |
| req_id_o | output | 5 | Index of the winning source |
| req_level_o | output | 2 | Group level of the winning source |

## Verification
Two functions can act on the same pending bit in one edge: the acknowledge clear and a new request on that source. The bench makes source 5 the only pending source, then raises ack_i and irq_i[5] together for one cycle. It expects source 5 to still be presented two edges later. It then repeats the acknowledge without the request and expects req_valid_o to fall. A second overlap, a register write while requests are pending, is judged by the winner changing exactly one edge after the write edge.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NUM_SRC = 24;
  localparam int NUM_GRP = 6;
  localparam int NUM_EN  = NUM_SRC / NUM_GRP;
  localparam int ID_W    = $clog2(NUM_SRC);
  localparam int LVL_W   = 2;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = NUM_GRP + 1;
  localparam int GIE_BIT = NUM_GRP;
  localparam int PRIO_LO_ADDR = NUM_EN;
  localparam int PRIO_HI_ADDR = NUM_EN + 1;

  typedef struct packed {
    logic             valid;
    logic [ID_W-1:0]  id;
    logic [LVL_W-1:0] level;
  } pick_t;
endpackage

// File: rtl/irq_arb_regs.sv
module irq_arb_regs import irq_arb_pkg::*; (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   gie_o,
  output logic [NUM_SRC-1:0]     en_o,
  output logic [NUM_GRP*LVL_W-1:0] lvl_o
);
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_GRP-1:0] lo_q, hi_q;
  logic               gie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      gie_q <= 1'b0;
    end else if (we_i) begin
      for (int r = 0; r < NUM_EN; r++)
        if (addr_i == ADDR_W'(r)) en_q[r*NUM_GRP +: NUM_GRP] <= wdata_i[NUM_GRP-1:0];
      if (addr_i == '0)                     gie_q <= wdata_i[GIE_BIT];
      if (addr_i == ADDR_W'(PRIO_LO_ADDR))  lo_q  <= wdata_i[NUM_GRP-1:0];
      if (addr_i == ADDR_W'(PRIO_HI_ADDR))  hi_q  <= wdata_i[NUM_GRP-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < NUM_EN; r++)
      if (addr_i == ADDR_W'(r)) rdata_o[NUM_GRP-1:0] = en_q[r*NUM_GRP +: NUM_GRP];
    if (addr_i == '0)                    rdata_o[GIE_BIT]     = gie_q;
    if (addr_i == ADDR_W'(PRIO_LO_ADDR)) rdata_o[NUM_GRP-1:0] = lo_q;
    if (addr_i == ADDR_W'(PRIO_HI_ADDR)) rdata_o[NUM_GRP-1:0] = hi_q;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_lvl
    assign lvl_o[g*LVL_W +: LVL_W] = {hi_q[g], lo_q[g]};
  end

  assign gie_o = gie_q;
  assign en_o  = en_q;
endmodule

// File: rtl/irq_arb_pending.sv
module irq_arb_pending import irq_arb_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               clr_i,
  input  logic [ID_W-1:0]    clr_id_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] pend_q, clr_mask;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
    assign clr_mask[i] = clr_i && (clr_id_i == ID_W'(i));
  end

  // a new request dominates a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_mask) | irq_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_arb_select.sv
module irq_arb_select import irq_arb_pkg::*; (
  input  logic [NUM_SRC-1:0]       cand_i,
  input  logic [NUM_GRP*LVL_W-1:0] lvl_i,
  output pick_t                    pick_o
);
  // strict compare keeps the lowest index on equal level
  always_comb begin
    pick_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand_i[i] && (!pick_o.valid ||
          lvl_i[(i % NUM_GRP)*LVL_W +: LVL_W] > pick_o.level)) begin
        pick_o.valid = 1'b1;
        pick_o.id    = ID_W'(i);
        pick_o.level = lvl_i[(i % NUM_GRP)*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irq_group_arbiter.sv
module irq_group_arbiter import irq_arb_pkg::*; (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_SRC-1:0]    irq_i,
  input  logic                  reg_we_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  input  logic                  ack_i,
  output logic                  req_valid_o,
  output logic [ID_W-1:0]       req_id_o,
  output logic [LVL_W-1:0]      req_level_o
);
  logic                       gie;
  logic [NUM_SRC-1:0]         en, pend_q, cand;
  logic [NUM_GRP*LVL_W-1:0]   lvl_vec;
  pick_t                      pick, pick_q;

  irq_arb_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .gie_o(gie), .en_o(en), .lvl_o(lvl_vec)
  );

  irq_arb_pending u_pend (
    .clk_i, .rst_ni, .irq_i,
    .clr_i(ack_i && pick_q.valid), .clr_id_i(pick_q.id),
    .pend_o(pend_q)
  );

  assign cand = pend_q & en & {NUM_SRC{gie}};

  irq_arb_select u_sel (.cand_i(cand), .lvl_i(lvl_vec), .pick_o(pick));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pick_q <= '0;
    else         pick_q <= pick;
  end

  assign req_valid_o = pick_q.valid;
  assign req_id_o    = pick_q.id;
  assign req_level_o = pick_q.level;
endmodule

module irq_group_arbiter_chk import irq_arb_pkg::*; (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_SRC-1:0]       irq_i,
  input logic                     ack_i,
  input logic                     gie,
  input logic [NUM_SRC-1:0]       cand,
  input logic [NUM_SRC-1:0]       pend_q,
  input logic [NUM_GRP*LVL_W-1:0] lvl_vec,
  input logic                     req_valid_o,
  input logic [ID_W-1:0]          req_id_o,
  input logic [LVL_W-1:0]         req_level_o
);
  logic [NUM_SRC-1:0]       cand_d;
  logic [NUM_GRP*LVL_W-1:0] lvl_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin cand_d <= '0; lvl_d <= '0; end
    else         begin cand_d <= cand; lvl_d <= lvl_vec; end
  end

  // R7
  winner_eligible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_id_o < ID_W'(NUM_SRC)) && cand_d[req_id_o]);
  // R4
  level_matches_group_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_id_o < ID_W'(NUM_SRC)) |->
      req_level_o == lvl_d[(32'(req_id_o) % NUM_GRP)*LVL_W +: LVL_W]);
  // R6
  gie_off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie |=> !req_valid_o);
  // R8
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && req_valid_o && !irq_i[req_id_o]) |=> !pend_q[$past(req_id_o)]);
  // R9
  set_beats_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && req_valid_o && irq_i[req_id_o]) |=> pend_q[$past(req_id_o)]);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cand) == '0) |-> !req_valid_o);
endmodule

bind irq_group_arbiter irq_group_arbiter_chk chk_i (
  .clk_i, .rst_ni, .irq_i, .ack_i, .gie, .cand, .pend_q, .lvl_vec,
  .req_valid_o, .req_id_o, .req_level_o
);

// File: tb/irq_group_arbiter_tb.sv
`timescale 1ns/1ps
module irq_group_arbiter_tb_top;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [23:0] irq = '0;
  logic        we = 1'b0, ack = 1'b0;
  logic [2:0]  addr = '0;
  logic [6:0]  wdata = '0;
  logic [6:0]  rdata;
  logic        valid;
  logic [4:0]  id;
  logic [1:0]  lvl;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  irq_group_arbiter dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ack_i(ack), .req_valid_o(valid), .req_id_o(id), .req_level_o(lvl)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_pick(input string req, input int v, input int i, input int l);
    check({req, " valid"}, int'(valid), v);
    if (v != 0) begin
      check({req, " id"}, int'(id), i);
      check({req, " level"}, int'(lvl), l);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; irq = '0; we = 1'b0; ack = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // one-cycle write; result visible after the following edge
  task automatic wr(input int a, input int d);
    we = 1'b1; addr = 3'(a); wdata = 7'(d);
    @(negedge clk);
    we = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse(input logic [23:0] v);
    irq = v;
    @(negedge clk);
    irq = '0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_ack(input logic [23:0] v);
    ack = 1'b1; irq = v;
    @(negedge clk);
    ack = 1'b0; irq = '0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic enable_all();
    wr(0, 7'h7F); wr(1, 7'h3F); wr(2, 7'h3F); wr(3, 7'h3F);
  endtask

  task automatic t_reset();
    do_reset();
    expect_pick("R1", 0, 0, 0);
    check("R1 id", int'(id), 0);
    check("R1 level", int'(lvl), 0);
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #1;
      check("R1 rdata", int'(rdata), 0);
    end
  endtask

  task automatic t_single();
    do_reset(); enable_all();
    irq = 24'(1) << 9;
    @(negedge clk);
    irq = '0;
    check("R2 one edge", int'(valid), 0);
    @(posedge clk); @(negedge clk);
    expect_pick("R2", 1, 9, 0);
    repeat (3) @(negedge clk);
    expect_pick("R2 held", 1, 9, 0);
  endtask

  task automatic t_levels();
    do_reset(); enable_all();
    wr(4, 7'h05); wr(5, 7'h04);       // grp2=3, grp0=1
    pulse((24'(1) << 0) | (24'(1) << 6) | (24'(1) << 8) | (24'(1) << 14));
    expect_pick("R4 grp2 top", 1, 8, 3);
    do_ack('0);
    expect_pick("R5 in-group", 1, 14, 3);
    do_ack('0);
    expect_pick("R3 grp0 lvl1", 1, 0, 1);
    do_ack('0);
    expect_pick("R5 next", 1, 6, 1);
    do_ack('0);
    expect_pick("R8 empty", 0, 0, 0);
  endtask

  task automatic t_ties();
    do_reset(); enable_all();
    pulse((24'(1) << 23) | (24'(1) << 3));
    expect_pick("R5 default lvl0", 1, 3, 0);
    wr(4, 7'h00); wr(5, 7'h22);       // grp5=2, grp1=2
    do_ack('0);
    pulse((24'(1) << 11) | (24'(1) << 19));
    expect_pick("R5 cross-group", 1, 11, 2);
  endtask

  task automatic t_gie();
    do_reset();
    wr(0, 7'h3F); wr(1, 7'h3F); wr(2, 7'h3F); wr(3, 7'h3F);
    pulse(24'(1) << 4);
    expect_pick("R6 gated", 0, 0, 0);
    repeat (2) @(negedge clk);
    check("R6 still gated", int'(valid), 0);
    wr(0, 7'h7F);
    expect_pick("R6 kept pending", 1, 4, 0);
  endtask

  task automatic t_enable();
    do_reset(); enable_all();
    wr(0, 7'h6F);                      // source 4 off
    pulse((24'(1) << 4) | (24'(1) << 20));
    expect_pick("R7 masked", 1, 20, 0);
    wr(0, 7'h7F);
    expect_pick("R7 re-enabled", 1, 4, 0);
  endtask

  task automatic t_collide();
    do_reset(); enable_all();
    pulse(24'(1) << 5);
    expect_pick("R9 setup", 1, 5, 0);
    do_ack(24'(1) << 5);
    expect_pick("R9 kept", 1, 5, 0);
    do_ack('0);
    expect_pick("R8 cleared", 0, 0, 0);
  endtask

  task automatic t_regs();
    do_reset();
    wr(0, 7'h7F); addr = 3'd0; #1; check("R10 addr0", int'(rdata), 7'h7F);
    wr(4, 7'h7F); addr = 3'd4; #1; check("R10 addr4", int'(rdata), 7'h3F);
    wr(2, 7'h55); addr = 3'd2; #1; check("R10 addr2", int'(rdata), 7'h15);
    wr(6, 7'h7F); addr = 3'd6; #1; check("R10 addr6", int'(rdata), 0);
    addr = 3'd5; #1; check("R10 addr5", int'(rdata), 0);
  endtask

  task automatic t_write_timing();
    do_reset(); enable_all();
    pulse(24'(1) << 2);
    expect_pick("R11 before", 1, 2, 0);
    we = 1'b1; addr = 3'd4; wdata = 7'h04;
    @(negedge clk);
    we = 1'b0;
    check("R11 not yet", int'(lvl), 0);
    @(posedge clk); @(negedge clk);
    expect_pick("R11 after", 1, 2, 1);
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_levels();
    t_ties();
    t_gie();
    t_enable();
    t_collide();
    t_regs();
    t_write_timing();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule